// File: doc/BRIEF.md
# Stack and Interrupt Sequencer

This block carries out the control-flow operations of an 8-bit processor that go through the stack. These are subroutine call and return, software break, return from interrupt, and the push and pull of the accumulator and of the status register. The instruction decoder starts an operation with a one-cycle `start` pulse. With the pulse it supplies an operation code, the address of the instruction, the call target and the current accumulator. The sequencer then drives a byte-wide memory port for one access per cycle. It pulses `done` once the operation has finished.

The sequencer owns three registers: the 8-bit stack pointer, the 16-bit program counter and the 8-bit status register. The stack lives in a fixed 256-byte page. A byte pulled into the accumulator is presented on `acc_out` with a one-cycle `acc_load` strobe.

Memory reads are registered. The byte for an address presented with `mem_re` in one cycle appears on `mem_rdata` in the next cycle.

Top module: `stack_irq_seq`

## Requirements
- R1: After reset, `sp` = 0xFD, `pc` = 0x0000, `busy` = 0, `done` = 0 and `status` = 0x24. The status bits from bit 7 down to bit 0 are N, V, U (unused), B, D, I, Z, C.
- R2: A push writes to 0x0100+SP and then decrements SP. A pull first increments SP and then reads 0x0100+SP. SP wraps modulo 256.
- R3: Push-accumulator (op 0) writes `acc_in` to the stack and leaves `status` unchanged.
- R4: Pull-accumulator (op 2) presents the pulled byte on `acc_out` with `acc_load` = 1 in the `done` cycle. It sets N to bit 7 of the byte and sets Z when the byte is zero. All other status bits stay as they were.
- R5: Push-status (op 1) writes `status` with B (bit 4) set to 1. The live `status` is not changed.
- R6: Pull-status (op 3) loads the pulled byte with U (bit 5) forced to 1 and B (bit 4) forced to 0.
- R7: Call (op 4) pushes `inst_addr`+2 (mod 2^16), high byte first and then low byte. It then sets `pc` to `target`.
- R8: Return (op 5) pulls the low byte and then the high byte, and sets `pc` to that address plus 1 (mod 2^16).
- R9: Break (op 6) pushes `inst_addr`+2, high byte and then low byte. It then pushes `status` with B set. Next it sets I (bit 2) and reads 0xFFFE (low byte) and then 0xFFFF (high byte) into `pc`. The live B bit is left unchanged.
- R10: Return-from-interrupt (op 7) first pulls the status byte, with only U forced to 1. It then pulls the PC low byte and then the high byte, and adds nothing to the result.
- R11: At most one of `mem_we` and `mem_re` is high in a cycle. A `start` while `busy` is high is ignored.
- R12: `busy` rises in the cycle after `start`. The number of busy cycles is 1 for push-accumulator and push-status, 2 for pull-accumulator, pull-status and call, 3 for return, 6 for break and 4 for return-from-interrupt. `done` is a single-cycle pulse in the cycle after the last busy cycle. Each result is visible in that `done` cycle, and SP does not change while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code, encoded as in R3 to R10 |
| inst_addr | input | 16 | Address of the stack instruction |
| target | input | 16 | Call destination |
| acc_in | input | 8 | Accumulator value to push |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status register |
| acc_out | output | 8 | Byte pulled for the accumulator |
| acc_load | output | 1 | `acc_out` is valid this cycle |

## Verification
A stack pointer that is off by one shows up in the very next push, because the byte lands in the wrong page-1 slot. It also shows up on `sp` in the `done` cycle, and the following pull then returns a neighbouring byte. A wrong step count or a wrong byte order in the return and break sequences appears as a wrong `pc` or a wrong cycle count within the same operation. Errors in forcing the status bits appear either in the pushed byte or in `status` as soon as the next `done` arrives. The sweeps run every byte value through both status paths and both accumulator paths.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int STEP_W = 3;

  // status bit positions
  localparam int ST_N = 7;
  localparam int ST_V = 6;
  localparam int ST_U = 5;
  localparam int ST_B = 4;
  localparam int ST_D = 3;
  localparam int ST_I = 2;
  localparam int ST_Z = 1;
  localparam int ST_C = 0;

  localparam logic [DATA_W-1:0] ST_RESET = DATA_W'((1 << ST_U) | (1 << ST_I));

  typedef enum logic [2:0] {
    OP_PUSH_A = 3'd0,
    OP_PUSH_P = 3'd1,
    OP_PULL_A = 3'd2,
    OP_PULL_P = 3'd3,
    OP_CALL   = 3'd4,
    OP_RET    = 3'd5,
    OP_BRK    = 3'd6,
    OP_RTI    = 3'd7
  } seq_op_e;

  // memory access performed in a step
  typedef enum logic [2:0] {
    MA_NONE,
    MA_WR_PCH,
    MA_WR_PCL,
    MA_WR_ST,
    MA_WR_ACC,
    MA_RD_STK,
    MA_RD_VLO,
    MA_RD_VHI
  } mem_act_e;

  // what the step does with the byte read in the previous step
  typedef enum logic [2:0] {
    CAP_NONE,
    CAP_LO,
    CAP_ACC,
    CAP_ST_PULL,
    CAP_ST_RTI,
    CAP_PC_RET,
    CAP_PC_ABS,
    CAP_PC_TGT
  } cap_e;

  typedef struct packed {
    mem_act_e act;
    cap_e     cap;
    logic     set_i;
    logic     last;
  } uop_t;

  function automatic logic [ADDR_W-1:0] call_ret_addr(input logic [ADDR_W-1:0] ia);
    return ia + ADDR_W'(2);
  endfunction

  function automatic logic [ADDR_W-1:0] sub_return_pc(input logic [DATA_W-1:0] lo,
                                                       input logic [DATA_W-1:0] hi);
    return {hi, lo} + ADDR_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] pushed_status(input logic [DATA_W-1:0] p);
    logic [DATA_W-1:0] r;
    r = p;
    r[ST_B] = 1'b1;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pulled_status(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    r[ST_U] = 1'b1;
    r[ST_B] = 1'b0;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] rti_status(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    r[ST_U] = 1'b1;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] load_nz(input logic [DATA_W-1:0] p,
                                                 input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = p;
    r[ST_N] = d[DATA_W-1];
    r[ST_Z] = (d == '0);
    return r;
  endfunction
endpackage

// File: rtl/stack_seq_ucode.sv
module stack_seq_ucode
  import stack_seq_pkg::*;
(
  input  seq_op_e             op,
  input  logic [STEP_W-1:0]   step,
  output uop_t                uop
);
  function automatic uop_t mk(input mem_act_e a, input cap_e c, input logic si, input logic l);
    uop_t u;
    u.act = a;
    u.cap = c;
    u.set_i = si;
    u.last = l;
    return u;
  endfunction

  always_comb begin
    uop = mk(MA_NONE, CAP_NONE, 1'b0, 1'b1);
    unique case (op)
      OP_PUSH_A: uop = mk(MA_WR_ACC, CAP_NONE, 1'b0, 1'b1);
      OP_PUSH_P: uop = mk(MA_WR_ST, CAP_NONE, 1'b0, 1'b1);
      OP_PULL_A: begin
        if (step == 3'd0) uop = mk(MA_RD_STK, CAP_NONE, 1'b0, 1'b0);
        else              uop = mk(MA_NONE, CAP_ACC, 1'b0, 1'b1);
      end
      OP_PULL_P: begin
        if (step == 3'd0) uop = mk(MA_RD_STK, CAP_NONE, 1'b0, 1'b0);
        else              uop = mk(MA_NONE, CAP_ST_PULL, 1'b0, 1'b1);
      end
      OP_CALL: begin
        if (step == 3'd0) uop = mk(MA_WR_PCH, CAP_NONE, 1'b0, 1'b0);
        else              uop = mk(MA_WR_PCL, CAP_PC_TGT, 1'b0, 1'b1);
      end
      OP_RET: begin
        unique case (step)
          3'd0:    uop = mk(MA_RD_STK, CAP_NONE, 1'b0, 1'b0);
          3'd1:    uop = mk(MA_RD_STK, CAP_LO, 1'b0, 1'b0);
          default: uop = mk(MA_NONE, CAP_PC_RET, 1'b0, 1'b1);
        endcase
      end
      OP_BRK: begin
        unique case (step)
          3'd0:    uop = mk(MA_WR_PCH, CAP_NONE, 1'b0, 1'b0);
          3'd1:    uop = mk(MA_WR_PCL, CAP_NONE, 1'b0, 1'b0);
          3'd2:    uop = mk(MA_WR_ST, CAP_NONE, 1'b0, 1'b0);
          3'd3:    uop = mk(MA_RD_VLO, CAP_NONE, 1'b1, 1'b0);
          3'd4:    uop = mk(MA_RD_VHI, CAP_LO, 1'b0, 1'b0);
          default: uop = mk(MA_NONE, CAP_PC_ABS, 1'b0, 1'b1);
        endcase
      end
      OP_RTI: begin
        unique case (step)
          3'd0:    uop = mk(MA_RD_STK, CAP_NONE, 1'b0, 1'b0);
          3'd1:    uop = mk(MA_RD_STK, CAP_ST_RTI, 1'b0, 1'b0);
          3'd2:    uop = mk(MA_RD_STK, CAP_LO, 1'b0, 1'b0);
          default: uop = mk(MA_NONE, CAP_PC_ABS, 1'b0, 1'b1);
        endcase
      end
      default: uop = mk(MA_NONE, CAP_NONE, 1'b0, 1'b1);
    endcase
  end
endmodule

// File: rtl/stack_seq_sp.sv
module stack_seq_sp
  import stack_seq_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_SP   = 8'hFD,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pull,
  output logic [DATA_W-1:0] sp,
  output logic [ADDR_W-1:0] stk_addr
);
  logic [DATA_W-1:0] sp_q;
  logic [DATA_W-1:0] sp_inc;

  assign sp_inc   = sp_q + DATA_W'(1);
  assign sp       = sp_q;
  // pull pre-increments, push post-decrements
  assign stk_addr = {STACK_PAGE, (pull ? sp_inc : sp_q)};

  always_ff @(posedge clk) begin
    if (!rst_n)    sp_q <= RESET_SP;
    else if (push) sp_q <= sp_q - DATA_W'(1);
    else if (pull) sp_q <= sp_inc;
  end
endmodule

// File: rtl/stack_seq_flags.sv
module stack_seq_flags
  import stack_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  cap_e              cap,
  input  logic              set_i,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] status
);
  logic [DATA_W-1:0] st_q;
  logic [DATA_W-1:0] st_d;

  always_comb begin
    st_d = st_q;
    if (en) begin
      unique case (cap)
        CAP_ACC:     st_d = load_nz(st_q, rdata);
        CAP_ST_PULL: st_d = pulled_status(rdata);
        CAP_ST_RTI:  st_d = rti_status(rdata);
        default:     st_d = st_q;
      endcase
      if (set_i) st_d[ST_I] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_RESET;
    else        st_q <= st_d;
  end

  assign status = st_q;
endmodule

// File: rtl/stack_irq_seq.sv
module stack_irq_seq
  import stack_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC   = 16'h0000,
  parameter logic [DATA_W-1:0] RESET_SP   = 8'hFD,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0] BRK_VEC    = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [15:0] inst_addr,
  input  logic [15:0] target,
  input  logic [7:0]  acc_in,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic [15:0] pc,
  output logic [7:0]  sp,
  output logic [7:0]  status,
  output logic [7:0]  acc_out,
  output logic        acc_load
);
  seq_op_e           op_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q, done_q;
  logic [ADDR_W-1:0] ret_q, tgt_q, pc_q;
  logic [DATA_W-1:0] acc_q, lo_q, acc_out_q;
  logic              acc_load_q;
  uop_t              uop;
  logic [ADDR_W-1:0] stk_addr;

  // named internal events
  logic op_accept, stk_push, stk_pull, vec_rd, step_end;

  assign op_accept = start && !busy_q;
  assign stk_push  = busy_q && (uop.act inside {MA_WR_PCH, MA_WR_PCL, MA_WR_ST, MA_WR_ACC});
  assign stk_pull  = busy_q && (uop.act == MA_RD_STK);
  assign vec_rd    = busy_q && (uop.act inside {MA_RD_VLO, MA_RD_VHI});
  assign step_end  = busy_q && uop.last;

  stack_seq_ucode u_ucode (
    .op   (op_q),
    .step (step_q),
    .uop  (uop)
  );

  stack_seq_sp #(
    .RESET_SP   (RESET_SP),
    .STACK_PAGE (STACK_PAGE)
  ) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (stk_push),
    .pull     (stk_pull),
    .sp       (sp),
    .stk_addr (stk_addr)
  );

  stack_seq_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (busy_q),
    .cap    (uop.cap),
    .set_i  (uop.set_i),
    .rdata  (mem_rdata),
    .status (status)
  );

  // memory port
  always_comb begin
    unique case (uop.act)
      MA_RD_VLO: mem_addr = BRK_VEC;
      MA_RD_VHI: mem_addr = BRK_VEC + ADDR_W'(1);
      default:   mem_addr = stk_addr;
    endcase
    unique case (uop.act)
      MA_WR_PCH: mem_wdata = ret_q[ADDR_W-1:DATA_W];
      MA_WR_PCL: mem_wdata = ret_q[DATA_W-1:0];
      MA_WR_ST:  mem_wdata = pushed_status(status);
      MA_WR_ACC: mem_wdata = acc_q;
      default:   mem_wdata = '0;
    endcase
  end

  assign mem_we = stk_push;
  assign mem_re = stk_pull || vec_rd;

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_PUSH_A;
      step_q <= '0;
      ret_q  <= '0;
      tgt_q  <= '0;
      acc_q  <= '0;
    end else begin
      done_q <= step_end;
      if (op_accept) begin
        busy_q <= 1'b1;
        op_q   <= seq_op_e'(op);
        step_q <= '0;
        ret_q  <= call_ret_addr(inst_addr);
        tgt_q  <= target;
        acc_q  <= acc_in;
      end else if (busy_q) begin
        step_q <= step_q + STEP_W'(1);
        if (uop.last) busy_q <= 1'b0;
      end
    end
  end

  // data captured from the previous step's read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q       <= RESET_PC;
      lo_q       <= '0;
      acc_out_q  <= '0;
      acc_load_q <= 1'b0;
    end else begin
      acc_load_q <= busy_q && (uop.cap == CAP_ACC);
      if (busy_q) begin
        unique case (uop.cap)
          CAP_LO:     lo_q <= mem_rdata;
          CAP_ACC:    acc_out_q <= mem_rdata;
          CAP_PC_RET: pc_q <= sub_return_pc(lo_q, mem_rdata);
          CAP_PC_ABS: pc_q <= {mem_rdata, lo_q};
          CAP_PC_TGT: pc_q <= tgt_q;
          default: ;
        endcase
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign pc       = pc_q;
  assign acc_out  = acc_out_q;
  assign acc_load = acc_load_q;
endmodule

// File: rtl/stack_irq_seq_chk.sv
module stack_irq_seq_chk
  import stack_seq_pkg::*;
#(
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0] BRK_VEC    = 16'hFFFE
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic [7:0]  sp,
  input logic [7:0]  status,
  input logic        stk_push,
  input logic        stk_pull,
  input logic        vec_rd,
  input logic [2:0]  op_q
);
  assert_port_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));

  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push |=> sp == $past(sp) - 8'd1);

  assert_pull_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stk_pull |=> sp == $past(sp) + 8'd1);

  assert_stack_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_push || stk_pull) |-> mem_addr[15:8] == STACK_PAGE);

  assert_vector_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |-> (mem_re && mem_addr[15:1] == BRK_VEC[15:1]));

  assert_unused_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_U]);

  assert_pull_b_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 3'd3) |-> !status[ST_B]);

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> op_q == $past(op_q));

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_idle_sp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(sp));
endmodule

bind stack_irq_seq stack_irq_seq_chk #(
  .STACK_PAGE (STACK_PAGE),
  .BRK_VEC    (BRK_VEC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr),
  .sp       (sp),
  .status   (status),
  .stk_push (stk_push),
  .stk_pull (stk_pull),
  .vec_rd   (vec_rd),
  .op_q     (op_q)
);

// File: tb/stack_irq_seq_tb.sv
module stack_irq_seq_tb;
  localparam logic [2:0] C_PUSHA = 3'd0, C_PUSHP = 3'd1, C_PULLA = 3'd2, C_PULLP = 3'd3,
                         C_CALL = 3'd4, C_RET = 3'd5, C_BRK = 3'd6, C_RTI = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [15:0] inst_addr = '0, target = '0;
  logic [7:0] acc_in = '0;
  logic [7:0] mem_rdata = '0;
  logic busy, done, mem_we, mem_re, acc_load;
  logic [15:0] mem_addr, pc;
  logic [7:0] mem_wdata, sp, status, acc_out;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  stack_irq_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .inst_addr(inst_addr),
    .target(target), .acc_in(acc_in), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .pc(pc), .sp(sp), .status(status), .acc_out(acc_out), .acc_load(acc_load)
  );

  // sparse memory: page 1 plus the two vector bytes
  logic [7:0] stk [256];
  logic [7:0] vlo = 8'h00, vhi = 8'h00;
  logic [7:0] rd_next = 8'h00;

  always @(negedge clk) begin
    if (mem_we) stk[mem_addr[7:0]] = mem_wdata;
    if (mem_re) begin
      if (mem_addr == 16'hFFFE)      rd_next = vlo;
      else if (mem_addr == 16'hFFFF) rd_next = vhi;
      else                           rd_next = stk[mem_addr[7:0]];
    end
  end
  always @(posedge clk) mem_rdata <= rd_next;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // issues one operation and checks its length (R12)
  task automatic run_op(input logic [2:0] o, input logic [15:0] ia, input logic [15:0] tg,
                        input logic [7:0] a, input int nlen);
    int cnt;
    @(negedge clk);
    op = o; inst_addr = ia; target = tg; acc_in = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 64) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == nlen + 1, "R12 op length", cnt, nlen + 1);
  endtask

  function automatic logic [7:0] nz(input logic [7:0] p, input logic [7:0] d);
    return (p & 8'h7D) | (d & 8'h80) | ((d == 8'h00) ? 8'h02 : 8'h00);
  endfunction

  logic [7:0] m_sp, m_st, e_st, sp0;
  logic [15:0] r_addr;

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sp == 8'hFD, "R1 sp", sp, 8'hFD);
    chk(status == 8'h24, "R1 status", status, 8'h24);
    chk(pc == 16'h0000, "R1 pc", pc, 0);
    chk(!busy && !done, "R1 idle", {busy, done}, 0);
    m_sp = 8'hFD;

    // status pull / push sweep (R5, R6)
    for (int d = 0; d < 256; d++) begin
      stk[8'(m_sp + 8'd1)] = 8'(d);
      run_op(C_PULLP, 16'h0, 16'h0, 8'h0, 2);
      m_sp = m_sp + 8'd1;
      e_st = (8'(d) | 8'h20) & 8'hEF;
      chk(status == e_st, "R6 pulled status", status, e_st);
      chk(sp == m_sp, "R2 sp after pull", sp, m_sp);
      run_op(C_PUSHP, 16'h0, 16'h0, 8'h0, 1);
      chk(stk[m_sp] == (e_st | 8'h10), "R5 pushed status byte", stk[m_sp], e_st | 8'h10);
      chk(status == e_st, "R5 live status kept", status, e_st);
      m_sp = m_sp - 8'd1;
      chk(sp == m_sp, "R2 sp after push", sp, m_sp);
    end
    m_st = 8'hEF;

    // accumulator push / pull sweep (R3, R4)
    for (int a = 0; a < 256; a++) begin
      run_op(C_PUSHA, 16'h0, 16'h0, 8'(a), 1);
      chk(stk[m_sp] == 8'(a), "R3 pushed acc", stk[m_sp], a);
      chk(status == m_st, "R3 flags unchanged", status, m_st);
      m_sp = m_sp - 8'd1;
      run_op(C_PULLA, 16'h0, 16'h0, 8'h0, 2);
      m_sp = m_sp + 8'd1;
      chk(acc_out == 8'(a) && acc_load, "R4 pulled acc", {acc_load, acc_out}, {1'b1, 8'(a)});
      m_st = nz(m_st, 8'(a));
      chk(status == m_st, "R4 N/Z", status, m_st);
      chk(sp == m_sp, "R2 sp after acc pair", sp, m_sp);
    end

    // stack pointer wrap (R2)
    while (m_sp != 8'h00) begin
      run_op(C_PUSHA, 16'h0, 16'h0, m_sp, 1);
      m_sp = m_sp - 8'd1;
    end
    run_op(C_PUSHA, 16'h0, 16'h0, 8'h5A, 1);
    chk(stk[0] == 8'h5A, "R2 write at 0x0100", stk[0], 8'h5A);
    chk(sp == 8'hFF, "R2 sp wrap down", sp, 8'hFF);
    run_op(C_PULLA, 16'h0, 16'h0, 8'h0, 2);
    chk(sp == 8'h00 && acc_out == 8'h5A, "R2 sp wrap up", {sp, acc_out}, {8'h00, 8'h5A});
    m_sp = 8'h00;
    m_st = nz(m_st, 8'h5A);

    // call / return (R7, R8)
    for (int k = 0; k < 5; k++) begin
      logic [15:0] ia, tg;
      case (k)
        0: begin ia = 16'h1234; tg = 16'hABCD; end
        1: begin ia = 16'hFFFE; tg = 16'h0010; end
        2: begin ia = 16'h00FF; tg = 16'hFFFF; end
        3: begin ia = 16'hFFFD; tg = 16'h8000; end
        default: begin ia = 16'h8001; tg = 16'h0000; end
      endcase
      r_addr = ia + 16'd2;
      run_op(C_CALL, ia, tg, 8'h0, 2);
      chk(stk[m_sp] == r_addr[15:8], "R7 high byte first", stk[m_sp], r_addr[15:8]);
      chk(stk[8'(m_sp - 8'd1)] == r_addr[7:0], "R7 low byte", stk[8'(m_sp - 8'd1)], r_addr[7:0]);
      chk(pc == tg, "R7 pc target", pc, tg);
      chk(sp == 8'(m_sp - 8'd2), "R7 sp", sp, 8'(m_sp - 8'd2));
      run_op(C_RET, 16'h0, 16'h0, 8'h0, 3);
      chk(pc == 16'(r_addr + 16'd1), "R8 return pc", pc, 16'(r_addr + 16'd1));
      chk(sp == m_sp, "R8 sp", sp, m_sp);
    end

    // break (R9) and return from interrupt (R10)
    stk[8'(m_sp + 8'd1)] = 8'hC3;
    run_op(C_PULLP, 16'h0, 16'h0, 8'h0, 2);
    m_sp = m_sp + 8'd1;
    chk(status == 8'hE3, "R6 setup status", status, 8'hE3);
    vlo = 8'h34; vhi = 8'h12;
    sp0 = m_sp;
    run_op(C_BRK, 16'h4000, 16'h0, 8'h0, 6);
    chk(stk[sp0] == 8'h40, "R9 pushed pc high", stk[sp0], 8'h40);
    chk(stk[8'(sp0 - 8'd1)] == 8'h02, "R9 pushed pc low", stk[8'(sp0 - 8'd1)], 8'h02);
    chk(stk[8'(sp0 - 8'd2)] == 8'hF3, "R9 pushed status", stk[8'(sp0 - 8'd2)], 8'hF3);
    chk(status == 8'hE7, "R9 I set, B kept", status, 8'hE7);
    chk(pc == 16'h1234, "R9 vector pc", pc, 16'h1234);
    chk(sp == 8'(sp0 - 8'd3), "R9 sp", sp, 8'(sp0 - 8'd3));
    run_op(C_RTI, 16'h0, 16'h0, 8'h0, 4);
    chk(status == 8'hF3, "R10 status B as pulled", status, 8'hF3);
    chk(pc == 16'h4002, "R10 pc no increment", pc, 16'h4002);
    chk(sp == sp0, "R10 sp", sp, sp0);
    stk[8'(m_sp + 8'd1)] = 8'h0C;
    stk[8'(m_sp + 8'd2)] = 8'h78;
    stk[8'(m_sp + 8'd3)] = 8'h56;
    run_op(C_RTI, 16'h0, 16'h0, 8'h0, 4);
    chk(status == 8'h2C, "R10 unused forced", status, 8'h2C);
    chk(pc == 16'h5678, "R10 pc", pc, 16'h5678);
    m_sp = m_sp + 8'd3;
    chk(sp == m_sp, "R10 sp", sp, m_sp);

    // start while busy is ignored (R11)
    vlo = 8'hCD; vhi = 8'hAB;
    sp0 = m_sp;
    @(negedge clk);
    op = C_BRK; inst_addr = 16'h2000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    op = C_PULLA; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 20 && !done; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(!busy, "R11 no extra operation", busy, 0);
    chk(sp == 8'(sp0 - 8'd3), "R11 sp only from break", sp, 8'(sp0 - 8'd3));
    chk(pc == 16'hABCD, "R11 pc from break", pc, 16'hABCD);
    chk(status[2] == 1'b1, "R9 I set again", status, 8'h04);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule